// File: doc/BRIEF.md
# Thermometer Scan Pattern Generator

This block drives a scan chain under diagnosis with a serial stimulus that holds one level, switches exactly once, and holds the other level. Each run applies one of four pattern kinds. A kind is fixed by two choices: whether it targets a setup-time or a hold-time cell fault, and whether its single edge rises or falls. One bit leaves the block per cycle, qualified by a valid strobe. A separate flag marks the one bit whose corruption reveals the fault.

A run is launched by a start strobe together with the pattern kind, the chain length L and the index of the cell that should end up holding the flagged bit. Index 0 is the cell at the scan output and index L-1 the cell at the scan input. The block first flushes the chain with L copies of the first pattern bit. It then emits the L-bit head of the pattern, whose final bit is the flagged one. It ends with L-1 minus the target index bits of the opposite level, which walk the flagged bit down to its target. After the last bit it raises a done level. The tester then captures and unloads the chain. Capture, unload and pattern search are outside this block.

Top module: `tsi_pattern_gen`

## Requirements
- R1: While reset is asserted and after its release, `bit_valid`, `sens_flag`, `done` and `bit_out` are all low until a start is accepted.
- R2: `pat_type` encodes the kind as 00 setup/rising, 01 hold/rising, 10 setup/falling, 11 hold/falling. The head fill level is `pat_type[1]` and the tail level is its inverse. The flagged bit takes the tail level for setup kinds (`pat_type[0]`=0) and the head fill level for hold kinds (`pat_type[0]`=1).
- R3: A start is accepted at a clock edge where it is high and the block is idle or done. From the next cycle the block emits L cycles of the head fill level with `bit_valid` high.
- R4: The next L valid cycles form the head. The first L-1 carry the head fill level and the last carries the flagged bit with `sens_flag` high. `sens_flag` is high in no other cycle.
- R5: Next come L-1-T cycles of the tail level, where T is `target_idx`. When T is L-1 or larger, this phase is empty.
- R6: `done` rises in the cycle after the final valid bit and stays high, with `bit_valid` low, until the next start is accepted.
- R7: A start strobe while `bit_valid` is high is ignored, and the bit stream in progress continues unchanged.
- R8: Within one run, `bit_out` changes level between two consecutive valid cycles only into or out of the flagged cycle.
- R9: A chain length of 0 is treated as a length of 1.
- R10: A start accepted while `done` is high begins a fresh run with the newly presented kind, length and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe, sampled at the clock edge |
| pat_type | input | 2 | Pattern kind, encoding in R2 |
| chain_len | input | LEN_W | Number of cells L in the chain |
| target_idx | input | LEN_W | Cell index that must receive the flagged bit |
| bit_out | output | 1 | Serial pattern bit |
| bit_valid | output | 1 | High when `bit_out` carries a pattern bit |
| sens_flag | output | 1 | High when `bit_out` carries the flagged bit |
| done | output | 1 | Run complete, held until the next accepted start |

## Verification
The case hardest to bring about is a start strobe that lands while a stream is already running. It must leave the stream untouched. The bench raises the strobe with a different kind, length and target in the middle of the flush phase and in the middle of the head. It then checks every later bit against the stream it originally requested. The boundary shift counts are also reached from the ports: a target at L-1, a target beyond the chain, and a zero length each make the positioning phase empty. In those cases the flagged bit must be the last bit before `done`.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_HEAD,
        PH_WALK,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/tsi_level_map.sv
module tsi_level_map (
    input  logic [1:0] pat_type,
    output logic       fill_lvl,
    output logic       tail_lvl,
    output logic       sens_lvl
);
    always_comb begin
        fill_lvl = pat_type[1];
        tail_lvl = ~pat_type[1];
        sens_lvl = pat_type[0] ? pat_type[1] : ~pat_type[1];
    end
endmodule

// File: rtl/tsi_shift_calc.sv
module tsi_shift_calc #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] len_raw,
    input  logic [LEN_W-1:0] target,
    output logic [LEN_W-1:0] len_eff,
    output logic [LEN_W-1:0] walk_cnt
);
    logic [LEN_W-1:0] top_idx;

    always_comb begin
        len_eff  = (len_raw == '0) ? LEN_W'(1) : len_raw;
        top_idx  = len_eff - LEN_W'(1);
        walk_cnt = (target >= top_idx) ? '0 : (top_idx - target);
    end
endmodule

// File: rtl/tsi_pattern_gen.sv
module tsi_pattern_gen #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       pat_type,
    input  logic [LEN_W-1:0] chain_len,
    input  logic [LEN_W-1:0] target_idx,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             sens_flag,
    output logic             done
);
    import tsi_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] walk;
        logic [1:0]       kind;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic             fill_lvl, tail_lvl, sens_lvl;
    logic [LEN_W-1:0] len_eff, walk_cnt;
    logic             accept;
    logic             last_cnt;

    tsi_level_map u_map (
        .pat_type (st_q.kind),
        .fill_lvl (fill_lvl),
        .tail_lvl (tail_lvl),
        .sens_lvl (sens_lvl)
    );

    tsi_shift_calc #(.LEN_W(LEN_W)) u_calc (
        .len_raw  (chain_len),
        .target   (target_idx),
        .len_eff  (len_eff),
        .walk_cnt (walk_cnt)
    );

    assign accept   = start && ((st_q.phase == PH_IDLE) || (st_q.phase == PH_DONE));
    assign last_cnt = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.phase = PH_FLUSH;
            st_d.kind  = pat_type;
            st_d.len   = len_eff;
            st_d.walk  = walk_cnt;
            st_d.cnt   = len_eff - LEN_W'(1);
        end else begin
            case (st_q.phase)
                PH_FLUSH: begin
                    if (last_cnt) begin
                        st_d.phase = PH_HEAD;
                        st_d.cnt   = st_q.len - LEN_W'(1);
                    end else begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end
                end
                PH_HEAD: begin
                    if (last_cnt) begin
                        if (st_q.walk == '0) begin
                            st_d.phase = PH_DONE;
                        end else begin
                            st_d.phase = PH_WALK;
                            st_d.cnt   = st_q.walk - LEN_W'(1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end
                end
                PH_WALK: begin
                    if (last_cnt) begin
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.cnt = st_q.cnt - LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, len: '0, walk: '0, kind: 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bit_out   = 1'b0;
        sens_flag = 1'b0;
        bit_valid = 1'b0;
        case (st_q.phase)
            PH_FLUSH: begin
                bit_valid = 1'b1;
                bit_out   = fill_lvl;
            end
            PH_HEAD: begin
                bit_valid = 1'b1;
                sens_flag = last_cnt;
                bit_out   = last_cnt ? sens_lvl : fill_lvl;
            end
            PH_WALK: begin
                bit_valid = 1'b1;
                bit_out   = tail_lvl;
            end
            default: ;
        endcase
        done = (st_q.phase == PH_DONE);
    end

endmodule

// File: rtl/tsi_pattern_gen_chk.sv
module tsi_pattern_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bit_out,
    input logic bit_valid,
    input logic sens_flag,
    input logic done
);
    // R4
    sens_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sens_flag |-> bit_valid);

    // R4
    sens_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sens_flag |=> !sens_flag);

    // R6
    done_excl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bit_valid);

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && start) |=> (bit_valid || done));

    // R8
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && $past(bit_valid) && (bit_out != $past(bit_out)))
        |-> (sens_flag || $past(sens_flag)));
endmodule

bind tsi_pattern_gen tsi_pattern_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .sens_flag (sens_flag),
    .done      (done)
);

// File: tb/tsi_pattern_gen_test.sv
module tsi_pattern_gen_test;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    pat_type = 2'b00;
    logic [LW-1:0] chain_len = '0;
    logic [LW-1:0] target_idx = '0;
    logic          bit_out, bit_valid, sens_flag, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tsi_pattern_gen #(.LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_type(pat_type),
        .chain_len(chain_len), .target_idx(target_idx),
        .bit_out(bit_out), .bit_valid(bit_valid), .sens_flag(sens_flag), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one pattern and compares every cycle. ign_at >= 0 pulses a
    // disruptive start at that cycle index (R7).
    task automatic run_pattern(input logic [1:0] ty, input int len, input int tgt,
                               input int ign_at, input string req);
        int l_eff, walk, total;
        logic fill, tail, sens, eb;
        bit   es;
        l_eff = (len == 0) ? 1 : len;
        walk  = (tgt >= l_eff - 1) ? 0 : (l_eff - 1 - tgt);
        total = 2 * l_eff + walk;
        fill  = ty[1];
        tail  = ~ty[1];
        sens  = ty[0] ? ty[1] : ~ty[1];
        @(negedge clk);
        pat_type = ty; chain_len = LW'(len); target_idx = LW'(tgt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total; i++) begin
            if (i < l_eff) begin eb = fill; es = 1'b0; end
            else if (i < 2 * l_eff - 1) begin eb = fill; es = 1'b0; end
            else if (i == 2 * l_eff - 1) begin eb = sens; es = 1'b1; end
            else begin eb = tail; es = 1'b0; end
            chk(req, $sformatf("valid@%0d", i), int'(bit_valid), 1);
            chk(req, $sformatf("bit@%0d", i), int'(bit_out), int'(eb));
            chk(req, $sformatf("sens@%0d", i), int'(sens_flag), int'(es));
            chk("R6", $sformatf("done low@%0d", i), int'(done), 0);
            if (i == ign_at) begin
                start = 1'b1;
                pat_type = ~ty; chain_len = LW'(3); target_idx = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R6", "done after last bit", int'(done), 1);
        chk("R6", "valid low at done", int'(bit_valid), 0);
    endtask

    task automatic t_reset;
        chk("R1", "valid in reset", int'(bit_valid), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "valid idle", int'(bit_valid), 0);
        chk("R1", "sens idle", int'(sens_flag), 0);
        chk("R1", "done idle", int'(done), 0);
        chk("R1", "bit idle", int'(bit_out), 0);
    endtask

    task automatic t_all_types;
        for (int k = 0; k < 4; k++) run_pattern(2'(k), 6, 2, -1, "R2");
    endtask

    task automatic t_shift_bounds;
        run_pattern(2'b01, 5, 0, -1, "R5");
        run_pattern(2'b10, 5, 4, -1, "R5");
        run_pattern(2'b11, 5, 9, -1, "R5");
        run_pattern(2'b00, 1, 0, -1, "R4");
    endtask

    task automatic t_zero_len;
        run_pattern(2'b00, 0, 0, -1, "R9");
        run_pattern(2'b11, 0, 3, -1, "R9");
    endtask

    task automatic t_done_hold;
        run_pattern(2'b10, 4, 1, -1, "R3");
        repeat (7) @(negedge clk);
        chk("R6", "done held", int'(done), 1);
        chk("R6", "valid held low", int'(bit_valid), 0);
        run_pattern(2'b01, 7, 3, -1, "R10");
    endtask

    task automatic t_busy_start;
        run_pattern(2'b00, 8, 1, 3, "R7");
        run_pattern(2'b11, 8, 1, 10, "R7");
        run_pattern(2'b10, 10, 2, 18, "R8");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_all_types();
        t_shift_bounds();
        t_zero_len();
        t_done_hold();
        t_busy_start();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule